// File: doc/BRIEF.md
# Output-Compare Timer Channel

This block is a free-running timer with one compare channel. A prescaler divides the clock into counting ticks. A counter advances on each tick and returns to zero after it reaches a programmed reload value. Each time the counter reaches a programmed compare value, the channel applies one of three actions to a single output pin: invert the pin, drive it high, or drive it low.

A one-port write interface loads the prescale divisor, the reload value, the compare value and the compare action. A separate one-cycle step input advances the compare action while the timer keeps running. This input is meant for a push-button event that has already been synchronized and debounced. The typical use is a blinking or level-indicating output whose behaviour can be changed at run time without stopping the count.

Top module: `oc_timer`

## Requirements
- R1: After reset, `count_o` is 0, `oc_out` is 0, the prescale divisor is 0, the compare value is 0, the reload value is all ones, and the compare action is invert.
- R2: With a prescale value P, `count_o` changes exactly once every P+1 clock cycles and holds its value in every other cycle.
- R3: On a tick, a counter value greater than or equal to the reload value R goes to 0, so the counter period is R+1 ticks. A counter left above a newly lowered R returns to 0 on the next tick.
- R4: In invert mode (code 0), `oc_out` inverts on the clock edge at which `count_o` takes the compare value C.
- R5: In drive-high mode (code 1), `oc_out` becomes 1 on the edge at which `count_o` takes C, and stays 1 through later matches.
- R6: In drive-low mode (code 2), `oc_out` becomes 0 on the edge at which `count_o` takes C, and stays 0 through later matches.
- R7: A one-cycle pulse on `mode_step` advances the action in the order invert, drive-high, drive-low, invert. A step does not change `oc_out` by itself.
- R8: A write with `wr_addr` 0 loads the prescale value, 1 loads the reload value, 2 loads the compare value, and 3 loads the action from `wr_data[1:0]`. An action code of 3 is ignored. A mode write and a step in the same cycle give the written mode.
- R9: When a step and a compare match fall on the same edge, the match uses the action that was in force before that edge. The advanced action applies from the next match on.
- R10: `oc_out` changes only on the tick at which the counter enters C. While the counter holds C across several clocks under a nonzero prescale, the output changes once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | 2 | Selects prescale (0), reload (1), compare (2) or action (3) |
| wr_data | input | DW | Write data; DW is the larger of CNT_W and PSC_W |
| mode_step | input | 1 | One-cycle pulse that advances the compare action |
| count_o | output | CNT_W | Current counter value |
| oc_out | output | 1 | Compare channel output |

## Verification
A button step can land on the same clock edge as a compare match. The bench provokes this by raising `mode_step` at the falling edge where the counter shows C-1, with a prescale of zero, so that the step and the match fall on the next rising edge. Before that edge the bench sets the output to 1 in invert mode. It then expects 0 on that edge, because the old invert action still applies. At the following match it expects 1, because drive-high is now in force. A second collision, between a mode write and a step, is judged over two later matches: only the written drive-low mode keeps the output at 0 on both.

// File: rtl/oc_timer.sv
module oc_timer #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  localparam int DW = (CNT_W > PSC_W) ? CNT_W : PSC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             mode_step,
  output logic [CNT_W-1:0] count_o,
  output logic             oc_out
);

  localparam logic [1:0] M_INV = 2'd0;
  localparam logic [1:0] M_HI  = 2'd1;
  localparam logic [1:0] M_LO  = 2'd2;

  logic [PSC_W-1:0] psc_q, div_q;
  logic [CNT_W-1:0] arr_q, ccr_q, cnt_q, cnt_nxt;
  logic [1:0]       mode_q;
  logic             tick, hit, mode_wr;

  assign tick    = (div_q >= psc_q);
  assign cnt_nxt = (cnt_q >= arr_q) ? '0 : cnt_q + 1'b1;
  assign hit     = tick && (cnt_nxt == ccr_q);
  assign mode_wr = wr_en && (wr_addr == 2'd3) && (wr_data[1:0] != 2'd3);
  assign count_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
      arr_q <= '1;
      ccr_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0:    psc_q <= wr_data[PSC_W-1:0];
        2'd1:    arr_q <= wr_data[CNT_W-1:0];
        2'd2:    ccr_q <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      div_q <= '0;
      cnt_q <= cnt_nxt;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= M_INV;
    else if (mode_wr)
      mode_q <= wr_data[1:0];
    else if (mode_step)
      mode_q <= (mode_q == M_LO) ? M_INV : mode_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      oc_out <= 1'b0;
    else if (hit) begin
      case (mode_q)
        M_INV:   oc_out <= ~oc_out;
        M_HI:    oc_out <= 1'b1;
        M_LO:    oc_out <= 1'b0;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/oc_timer_chk.sv
module oc_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             hit,
  input logic             mode_wr,
  input logic             step,
  input logic [1:0]       wmode,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] arr,
  input logic [CNT_W-1:0] count,
  input logic             oc_out
);

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (count >= arr) |=> count == '0);

  // R4
  invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && mode == 2'd0 |=> oc_out != $past(oc_out));

  // R5
  drive_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && mode == 2'd1 |=> oc_out);

  // R6
  drive_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && mode == 2'd2 |=> !oc_out);

  // R7
  step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !mode_wr |=> mode == (($past(mode) == 2'd2) ? 2'd0 : $past(mode) + 2'd1));

  // R8
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> mode == $past(wmode));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(oc_out));

endmodule

bind oc_timer oc_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick),
  .hit    (hit),
  .mode_wr(mode_wr),
  .step   (mode_step),
  .wmode  (wr_data[1:0]),
  .mode   (mode_q),
  .arr    (arr_q),
  .count  (cnt_q),
  .oc_out (oc_out)
);

// File: tb/tb_oc_timer.sv
module tb_oc_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        mode_step = 1'b0;
  logic [15:0] count_o;
  logic        oc_out;
  int checks = 0;
  int errors = 0;

  oc_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_step(mode_step), .count_o(count_o), .oc_out(oc_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_step();
    @(negedge clk);
    mode_step = 1'b1;
    @(negedge clk);
    mode_step = 1'b0;
  endtask

  task automatic setup(input logic [15:0] p, input logic [15:0] r, input logic [15:0] c);
    do_reset();
    wr(2'd0, p);
    wr(2'd1, r);
    wr(2'd2, c);
  endtask

  task automatic wait_val(input logic [15:0] v);
    do @(negedge clk); while (count_o == v);
    do @(negedge clk); while (count_o != v);
  endtask

  task automatic t_reset();
    do_reset();
    chk(count_o == 0, "R1 count", count_o, 0);
    chk(oc_out == 0, "R1 out", oc_out, 0);
    wr(2'd1, 16'd9);
    wr(2'd2, 16'd4);
    wait_val(4);
    chk(oc_out == 1, "R1 invert after reset", oc_out, 1);
  endtask

  task automatic t_prescale(input int p);
    logic [15:0] c0, c1;
    int n;
    setup(p[15:0], 16'd1000, 16'd999);
    c0 = count_o;
    do @(negedge clk); while (count_o == c0);
    c1 = count_o;
    n = 0;
    do begin @(negedge clk); n++; end while (count_o == c1);
    chk(n == p + 1, "R2 tick spacing", n, p + 1);
    chk(count_o == c1 + 1, "R2 step size", count_o, c1 + 1);
  endtask

  task automatic t_wrap();
    int n;
    setup(16'd0, 16'd5, 16'd3);
    wait_val(5);
    @(negedge clk);
    chk(count_o == 0, "R3 wrap", count_o, 0);
    n = 0;
    do begin @(negedge clk); n++; end while (count_o != 0);
    chk(n == 6, "R3 period", n, 6);
    wr(2'd1, 16'd1000);
    wait_val(20);
    wr(2'd1, 16'd7);
    @(negedge clk);
    chk(count_o == 0, "R3 lowered reload", count_o, 0);
  endtask

  task automatic t_toggle(input int p);
    logic prev;
    setup(p[15:0], 16'd9, 16'd4);
    for (int i = 0; i < 3; i++) begin
      prev = oc_out;
      wait_val(4);
      chk(oc_out == !prev, "R4 invert on match", oc_out, !prev);
      for (int k = 0; k < p; k++) begin
        @(negedge clk);
        chk(oc_out == !prev, "R10 single action per value", oc_out, !prev);
      end
    end
  endtask

  task automatic t_hi_lo();
    setup(16'd0, 16'd9, 16'd4);
    wr(2'd3, 16'd1);
    chk(oc_out == 0, "R8 mode write leaves out", oc_out, 0);
    wait_val(4);
    chk(oc_out == 1, "R5 drive high", oc_out, 1);
    wait_val(4);
    chk(oc_out == 1, "R5 stays high", oc_out, 1);
    wr(2'd3, 16'd2);
    chk(oc_out == 1, "R8 mode write leaves out", oc_out, 1);
    wait_val(4);
    chk(oc_out == 0, "R6 drive low", oc_out, 0);
    wait_val(4);
    chk(oc_out == 0, "R6 stays low", oc_out, 0);
  endtask

  task automatic t_step();
    setup(16'd0, 16'd9, 16'd4);
    pulse_step();
    chk(oc_out == 0, "R7 step keeps out", oc_out, 0);
    wait_val(4);
    chk(oc_out == 1, "R7 second mode high", oc_out, 1);
    pulse_step();
    chk(oc_out == 1, "R7 step keeps out", oc_out, 1);
    wait_val(4);
    chk(oc_out == 0, "R7 third mode low", oc_out, 0);
    pulse_step();
    wait_val(4);
    chk(oc_out == 1, "R7 back to invert", oc_out, 1);
    wait_val(4);
    chk(oc_out == 0, "R7 back to invert", oc_out, 0);
  endtask

  task automatic t_mode_write();
    setup(16'd0, 16'd9, 16'd4);
    wr(2'd3, 16'd3);
    wait_val(4);
    chk(oc_out == 1, "R8 code 3 ignored", oc_out, 1);
    wait_val(4);
    chk(oc_out == 0, "R8 code 3 ignored", oc_out, 0);
    wait_val(4);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'd2; mode_step = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; mode_step = 1'b0;
    wait_val(4);
    chk(oc_out == 0, "R8 write beats step", oc_out, 0);
    wait_val(4);
    chk(oc_out == 0, "R8 write beats step", oc_out, 0);
  endtask

  task automatic t_collide();
    setup(16'd0, 16'd9, 16'd4);
    wait_val(4);
    chk(oc_out == 1, "R9 precondition", oc_out, 1);
    do @(negedge clk); while (count_o != 3);
    mode_step = 1'b1;
    @(negedge clk);
    mode_step = 1'b0;
    chk(count_o == 4, "R9 match edge", count_o, 4);
    chk(oc_out == 0, "R9 old mode on collision", oc_out, 0);
    wait_val(4);
    chk(oc_out == 1, "R9 new mode after", oc_out, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_prescale(0);
    t_prescale(2);
    t_prescale(5);
    t_wrap();
    t_toggle(0);
    t_toggle(2);
    t_hi_lo();
    t_step();
    t_mode_write();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule